// File: doc/BRIEF.md
# Four-Bank SDRAM Command Front-End

This block sits directly behind the command and address pins of a four-bank synchronous DRAM. On every rising clock edge it samples the chip select, the three command strobes, a two-bit bank number, a twelve-bit address and a four-bit byte mask. It turns them into one decoded command. It keeps, for every bank, whether the bank is open and which row it holds.

Column commands start bursts. The burst length comes from a mode word that a mode-set command loads from the address pins. While a burst runs, the block produces one column beat per cycle. Each beat carries the bank, the column and four byte-lane write enables, which go to the storage array. An address bit on a column command asks for the bank to close after its last beat. The same bit on a precharge selects between closing every bank and closing only the addressed one. The clock-enable input suspends the internal clock one cycle after it is sampled low.

The access output is a one-way stream with a valid flag and no ready. The storage array must accept a beat in every cycle in which `acc_valid_o` is high. There is no back-pressure. While the clock is suspended, the beat outputs hold their last values.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset, every bank is idle, `acc_valid_o`, `byte_we_o` and `proto_err_o` are low, `cmd_o` is 0, and the mode word is 0, which gives a burst length of 1.
- R2: An edge at which `cs_n_i` is high is a no-op: `cmd_o` becomes 0 and no bank state changes.
- R3: With `cs_n_i` low, the strobes `{ras,cas,we}` decode as follows: 011 activate (code 1), 010 precharge (code 2), 101 read (code 3), 100 write (code 4) and 000 mode set (code 5). Every other pattern is a no-op (code 0). `cmd_o` shows the code sampled at the last live edge.
- R4: Activate to an idle bank opens that bank and stores the twelve address bits as its row. The row of bank b appears at `open_rows_o[12b+11:12b]`.
- R5: Read or write to an open bank issues a beat at that edge. The beat carries column `addr[7:0]`, the bank, and the write flag.
- R6: The burst length comes from mode bits [2:0]: code 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8; other codes give 1. Each later beat advances the low log2(length) column bits and wraps within that aligned group. The upper column bits stay fixed.
- R7: A read or write that arrives during a burst ends the old burst and starts the new one at that edge.
- R8: With `addr[10]` high on a read or write, the bank closes at the edge that issues its last beat. If the burst is interrupted first, the bank closes at the interrupting edge.
- R9: Precharge with `addr[10]` high closes all banks. With `addr[10]` low, it closes only the addressed bank.
- R10: On a write beat, `byte_we_o[i]` is the inverse of `dqm_i[i]` sampled at that edge. Mask bit i covers data bits 8i+7 down to 8i. On read beats and when no beat is issued, `byte_we_o` is 0.
- R11: If `cke_i` is sampled low at an edge, the next edge is frozen. At a frozen edge, commands are ignored, the burst position does not advance, and every output keeps its value.
- R12: A read or write to an idle bank, or an activate to an open bank, sets `proto_err_o`. The flag stays set until reset. The offending command has no other effect.
- R13: Mode set loads the twelve address bits into the mode word. A burst started at a later edge uses the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; a low sample freezes the next edge |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| bank_i | input | 2 | Bank number |
| addr_i | input | 12 | Row, column, mode word or precharge-scope bit |
| dqm_i | input | 4 | Byte mask, high masks a lane |
| cmd_o | output | 3 | Code of the last decoded command |
| bank_active_o | output | 4 | Open flag for each bank |
| open_rows_o | output | 48 | Stored row for each bank |
| acc_valid_o | output | 1 | A column beat is present |
| acc_write_o | output | 1 | Beat is a write |
| acc_bank_o | output | 2 | Bank of the beat |
| acc_col_o | output | 8 | Column of the beat |
| byte_we_o | output | 4 | Byte-lane write enables |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The decoder and burst engine are tested with several input patterns:
- A four-beat write starting mid-group (column 6), which shows whether the column wraps inside its aligned group or carries into the upper bits.
- A four-beat read with the auto-close bit set, which shows whether the bank closes on the last beat and not before.
- A read burst cut short by a read to another bank, which separates interruption from a run to completion.
- Eight-beat and two-beat bursts, which test the remaining length codes.

The other cases are checked separately:
- Mixed byte masks on successive beats show that each beat uses the mask sampled at its own edge.
- A precharge-all sent during a frozen edge shows that the suspend discards commands as well as holding outputs.
- A repeated activate and a read to a closed bank show the error path.
- A select-high edge carrying activate strobes tells chip-select masking apart from decoding.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_MRS = 3'd5
  } cmd_e;

  // beats-minus-one mask for a burst-length code
  function automatic logic [2:0] len_mask(input logic [2:0] code);
    case (code)
      3'd1:    len_mask = 3'd1;
      3'd2:    len_mask = 3'd3;
      3'd3:    len_mask = 3'd7;
      default: len_mask = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdc_bank_table.sv
module sdc_bank_table #(
  parameter int NB = 4,
  parameter int RW = 12,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_valid,
  input  logic [BW-1:0] act_bank,
  input  logic [RW-1:0] act_row,
  input  logic          pre_valid,
  input  logic          pre_all,
  input  logic [BW-1:0] pre_bank,
  input  logic [NB-1:0] close_mask,
  output logic [NB-1:0] active_o,
  output logic [NB*RW-1:0] rows_o
);

  logic [NB-1:0] active_q;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [RW-1:0] row_q;
    logic          hit_act;
    logic          hit_close;

    assign hit_act   = act_valid && (act_bank == BW'(b));
    assign hit_close = (pre_valid && (pre_all || (pre_bank == BW'(b)))) || close_mask[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q[b] <= 1'b0;
        row_q       <= '0;
      end else if (hit_act) begin
        active_q[b] <= 1'b1;
        row_q       <= act_row;
      end else if (hit_close) begin
        active_q[b] <= 1'b0;
      end
    end

    assign rows_o[b*RW +: RW] = row_q;
  end

  assign active_o = active_q;

  // R4
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> active_q[$past(act_bank)]);

  // R9
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_valid && pre_all && !act_valid) |=> (active_q == '0));

endmodule

// File: rtl/sdc_burst.sv
module sdc_burst #(
  parameter int NB = 4,
  parameter int CW = 8,
  parameter int NBYTE = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             start_write,
  input  logic [BW-1:0]    start_bank,
  input  logic [CW-1:0]    start_col,
  input  logic             start_ap,
  input  logic [2:0]       len_mask,
  input  logic [NBYTE-1:0] dqm,
  output logic             valid_o,
  output logic             write_o,
  output logic [BW-1:0]    bank_o,
  output logic [CW-1:0]    col_o,
  output logic [NBYTE-1:0] bwe_o,
  output logic [NB-1:0]    close_mask_o
);

  logic             valid_q;
  logic             wr_q;
  logic             ap_q;
  logic [BW-1:0]    bank_q;
  logic [CW-1:0]    col_q;
  logic [NBYTE-1:0] bwe_q;
  logic [2:0]       rem_q;
  logic [CW-1:0]    grp_m;
  logic [CW-1:0]    col_nxt;
  logic [CW-1:0]    col_inc;

  assign grp_m   = CW'(len_mask_q);
  assign col_inc = col_q + 1'b1;
  assign col_nxt = (col_q & ~grp_m) | (col_inc & grp_m);

  // length captured at burst start so a later mode change does not bend it
  logic [2:0] len_mask_q;

  always_comb begin
    close_mask_o = '0;
    if (en) begin
      if (start) begin
        if ((rem_q != 3'd0) && ap_q) close_mask_o[bank_q] = 1'b1;
        if (start_ap && (len_mask == 3'd0)) close_mask_o[start_bank] = 1'b1;
      end else if ((rem_q == 3'd1) && ap_q) begin
        close_mask_o[bank_q] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      wr_q       <= 1'b0;
      ap_q       <= 1'b0;
      bank_q     <= '0;
      col_q      <= '0;
      bwe_q      <= '0;
      rem_q      <= '0;
      len_mask_q <= '0;
    end else if (en) begin
      if (start) begin
        valid_q    <= 1'b1;
        wr_q       <= start_write;
        ap_q       <= start_ap;
        bank_q     <= start_bank;
        col_q      <= start_col;
        rem_q      <= len_mask;
        len_mask_q <= len_mask;
        bwe_q      <= start_write ? ~dqm : '0;
      end else if (rem_q != 3'd0) begin
        valid_q <= 1'b1;
        col_q   <= col_nxt;
        rem_q   <= rem_q - 3'd1;
        bwe_q   <= wr_q ? ~dqm : '0;
      end else begin
        valid_q <= 1'b0;
        bwe_q   <= '0;
      end
    end
  end

  assign valid_o = valid_q;
  assign write_o = wr_q;
  assign bank_o  = bank_q;
  assign col_o   = col_q;
  assign bwe_o   = bwe_q;

  // R6
  burst_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && (rem_q != 3'd0)) |=> (col_q[CW-1:3] == $past(col_q[CW-1:3])));

  // R10
  read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q || !wr_q) |-> (bwe_q == '0));

  // R11
  freeze_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(col_q) && $stable(valid_q) && $stable(bwe_q) && $stable(rem_q)));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 32,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int NBYTE    = DATA_W / 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cke_i,
  input  logic                        cs_n_i,
  input  logic                        ras_n_i,
  input  logic                        cas_n_i,
  input  logic                        we_n_i,
  input  logic [BANK_W-1:0]           bank_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NBYTE-1:0]            dqm_i,
  output logic [2:0]                  cmd_o,
  output logic [NUM_BANKS-1:0]        bank_active_o,
  output logic [NUM_BANKS*ADDR_W-1:0] open_rows_o,
  output logic                        acc_valid_o,
  output logic                        acc_write_o,
  output logic [BANK_W-1:0]           acc_bank_o,
  output logic [COL_W-1:0]            acc_col_o,
  output logic [NBYTE-1:0]            byte_we_o,
  output logic                        proto_err_o
);

  cmd_e                 cmd;
  logic                 cke_q;
  logic                 en;
  logic [ADDR_W-1:0]    mode_q;
  logic [2:0]           cmd_q;
  logic                 err_q;
  logic [NUM_BANKS-1:0] active;
  logic [NUM_BANKS-1:0] close_mask;
  logic                 bank_open;
  logic                 is_col;
  logic                 act_ok;
  logic                 col_ok;
  logic                 bad;

  sdc_decode u_dec (
    .cs_n  (cs_n_i),
    .ras_n (ras_n_i),
    .cas_n (cas_n_i),
    .we_n  (we_n_i),
    .cmd   (cmd)
  );

  // clock-enable latency of one edge
  assign en        = cke_q;
  assign bank_open = active[bank_i];
  assign is_col    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign act_ok    = en && (cmd == CMD_ACT) && !bank_open;
  assign col_ok    = en && is_col && bank_open;
  assign bad       = en && (((cmd == CMD_ACT) && bank_open) || (is_col && !bank_open));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      mode_q <= '0;
      cmd_q  <= 3'd0;
      err_q  <= 1'b0;
    end else begin
      cke_q <= cke_i;
      if (en) begin
        cmd_q <= cmd;
        if (cmd == CMD_MRS) mode_q <= addr_i;
        if (bad) err_q <= 1'b1;
      end
    end
  end

  sdc_bank_table #(
    .NB (NUM_BANKS),
    .RW (ADDR_W)
  ) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_valid  (act_ok),
    .act_bank   (bank_i),
    .act_row    (addr_i),
    .pre_valid  (en && (cmd == CMD_PRE)),
    .pre_all    (addr_i[AP_BIT]),
    .pre_bank   (bank_i),
    .close_mask (close_mask),
    .active_o   (active),
    .rows_o     (open_rows_o)
  );

  sdc_burst #(
    .NB    (NUM_BANKS),
    .CW    (COL_W),
    .NBYTE (NBYTE)
  ) u_burst (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .start        (col_ok),
    .start_write  (cmd == CMD_WR),
    .start_bank   (bank_i),
    .start_col    (addr_i[COL_W-1:0]),
    .start_ap     (addr_i[AP_BIT]),
    .len_mask     (len_mask(mode_q[2:0])),
    .dqm          (dqm_i),
    .valid_o      (acc_valid_o),
    .write_o      (acc_write_o),
    .bank_o       (acc_bank_o),
    .col_o        (acc_col_o),
    .bwe_o        (byte_we_o),
    .close_mask_o (close_mask)
  );

  assign cmd_o         = cmd_q;
  assign bank_active_o = active;
  assign proto_err_o   = err_q;

  // R2
  cs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cs_n_i) |=> (cmd_o == 3'd0));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);

  // R11
  freeze_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(bank_active_o) && $stable(open_rows_o) && $stable(cmd_o)));

  // R5
  beat_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_ok |=> (acc_valid_o && (acc_col_o == $past(addr_i[COL_W-1:0]))));

endmodule

// File: tb/sdram_cmd_front_tb.sv
module sdram_cmd_front_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  bank;
  logic [11:0] addr;
  logic [3:0]  dqm;
  logic [2:0]  cmd_o;
  logic [3:0]  act_o;
  logic [47:0] rows_o;
  logic        v_o, w_o, err_o;
  logic [1:0]  b_o;
  logic [7:0]  c_o;
  logic [3:0]  we_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdram_cmd_front dut_i (
    .clk (clk), .rst_n (rst_n), .cke_i (cke), .cs_n_i (cs_n), .ras_n_i (ras_n),
    .cas_n_i (cas_n), .we_n_i (we_n), .bank_i (bank), .addr_i (addr), .dqm_i (dqm),
    .cmd_o (cmd_o), .bank_active_o (act_o), .open_rows_o (rows_o),
    .acc_valid_o (v_o), .acc_write_o (w_o), .acc_bank_o (b_o), .acc_col_o (c_o),
    .byte_we_o (we_o), .proto_err_o (err_o)
  );

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, PRE = 3'd2, RD = 3'd3, WR = 3'd4, MRS = 3'd5;

  // {cke, cmd, bank, addr, dqm, exp_valid, exp_write, exp_col, exp_bwe, exp_active, exp_err}
  localparam logic [40:0] VEC [0:22] = '{
    {1'b1, MRS, 2'd0, 12'h002, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 1'b0},
    {1'b1, ACT, 2'd1, 12'h123, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h2, 1'b0},
    {1'b1, WR,  2'd1, 12'h006, 4'h5, 1'b1, 1'b1, 8'h06, 4'hA, 4'h2, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b1, 1'b1, 8'h07, 4'hF, 4'h2, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'hF, 1'b1, 1'b1, 8'h04, 4'h0, 4'h2, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b1, 1'b1, 8'h05, 4'hF, 4'h2, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h2, 1'b0},
    {1'b1, RD,  2'd1, 12'h410, 4'h0, 1'b1, 1'b0, 8'h10, 4'h0, 4'h2, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b1, 1'b0, 8'h11, 4'h0, 4'h2, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b1, 1'b0, 8'h12, 4'h0, 4'h2, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b1, 1'b0, 8'h13, 4'h0, 4'h0, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 1'b0},
    {1'b1, ACT, 2'd0, 12'hABC, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h1, 1'b0},
    {1'b1, ACT, 2'd2, 12'h055, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h5, 1'b0},
    {1'b1, RD,  2'd0, 12'h020, 4'h0, 1'b1, 1'b0, 8'h20, 4'h0, 4'h5, 1'b0},
    {1'b1, RD,  2'd2, 12'h03E, 4'h0, 1'b1, 1'b0, 8'h3E, 4'h0, 4'h5, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b1, 1'b0, 8'h3F, 4'h0, 4'h5, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b1, 1'b0, 8'h3C, 4'h0, 4'h5, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b1, 1'b0, 8'h3D, 4'h0, 4'h5, 1'b0},
    {1'b1, NOP, 2'd0, 12'h000, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h5, 1'b0},
    {1'b1, PRE, 2'd2, 12'h000, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h1, 1'b0},
    {1'b1, PRE, 2'd3, 12'h400, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 1'b0},
    {1'b1, RD,  2'd0, 12'h000, 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic k, input logic [2:0] c, input logic [1:0] b,
                       input logic [11:0] a, input logic [3:0] m);
    cke = k; bank = b; addr = a; dqm = m;
    case (c)
      NOP:     {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      ACT:     {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      PRE:     {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      RD:      {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      WR:      {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      MRS:     {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    endcase
  endtask

  task automatic step(input logic k, input logic [2:0] c, input logic [1:0] b,
                      input logic [11:0] a, input logic [3:0] m);
    drive(k, c, b, a, m);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b1, 3'd7, 2'd0, 12'h000, 4'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();

    // table walk: R5 R6 R7 R8 R9 R10 R12 R13
    for (int i = 0; i < 23; i++) begin
      logic [40:0] v;
      v = VEC[i];
      step(v[40], v[39:37], v[36:35], v[34:23], v[22:19]);
      chk($sformatf("R5 valid vec%0d", i), 64'(v_o), 64'(v[18]));
      if (v[18]) begin
        chk($sformatf("R6 col vec%0d", i), 64'(c_o), 64'(v[16:9]));
        chk($sformatf("R5 write vec%0d", i), 64'(w_o), 64'(v[17]));
      end
      chk($sformatf("R10 bwe vec%0d", i), 64'(we_o), 64'(v[8:5]));
      chk($sformatf("R8/R9 active vec%0d", i), 64'(act_o), 64'(v[4:1]));
      chk($sformatf("R12 err vec%0d", i), 64'(err_o), 64'(v[0]));
    end

    // R1 reset state
    do_reset();
    chk("R1 active", 64'(act_o), 64'h0);
    chk("R1 valid", 64'(v_o), 64'h0);
    chk("R1 bwe", 64'(we_o), 64'h0);
    chk("R1 err", 64'(err_o), 64'h0);
    chk("R1 cmd", 64'(cmd_o), 64'h0);

    // R2 activate strobes with select high
    drive(1'b1, ACT, 2'd3, 12'hFED, 4'h0);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R2 active", 64'(act_o), 64'h0);
    chk("R2 cmd", 64'(cmd_o), 64'h0);

    // R4 R3 activate bank 3
    step(1'b1, ACT, 2'd3, 12'hFED, 4'h0);
    chk("R4 row", 64'(rows_o[47:36]), 64'hFED);
    chk("R4 active", 64'(act_o), 64'h8);
    chk("R3 act code", 64'(cmd_o), 64'd1);

    // R12 second activate to an open bank
    step(1'b1, ACT, 2'd3, 12'h111, 4'h0);
    chk("R12 err", 64'(err_o), 64'h1);
    chk("R12 row kept", 64'(rows_o[47:36]), 64'hFED);

    // R13 burst length 2
    step(1'b1, MRS, 2'd0, 12'h001, 4'h0);
    chk("R3 mrs code", 64'(cmd_o), 64'd5);

    // R11 write with clock enable dropped at the same edge
    step(1'b0, WR, 2'd3, 12'h0FF, 4'h0);
    chk("R11 first col", 64'(c_o), 64'hFF);
    chk("R11 first bwe", 64'(we_o), 64'hF);
    chk("R3 wr code", 64'(cmd_o), 64'd4);
    step(1'b1, PRE, 2'd0, 12'h400, 4'hF);
    chk("R11 frozen col", 64'(c_o), 64'hFF);
    chk("R11 frozen bwe", 64'(we_o), 64'hF);
    chk("R11 frozen valid", 64'(v_o), 64'h1);
    chk("R11 pre ignored", 64'(act_o), 64'h8);
    chk("R11 frozen cmd", 64'(cmd_o), 64'd4);
    step(1'b1, NOP, 2'd0, 12'h000, 4'h3);
    chk("R13 second col", 64'(c_o), 64'hFE);
    chk("R10 second bwe", 64'(we_o), 64'hC);
    step(1'b1, NOP, 2'd0, 12'h000, 4'h0);
    chk("R13 burst end", 64'(v_o), 64'h0);

    // R6 eight-beat read from column 5
    step(1'b1, MRS, 2'd0, 12'h003, 4'h0);
    step(1'b1, RD, 2'd3, 12'h005, 4'h0);
    chk("R3 rd code", 64'(cmd_o), 64'd3);
    chk("R6 col0", 64'(c_o), 64'h05);
    chk("R5 bank", 64'(b_o), 64'd3);
    for (int k = 1; k < 8; k++) begin
      step(1'b1, NOP, 2'd0, 12'h000, 4'h0);
      chk($sformatf("R6 col%0d", k), 64'(c_o), 64'((5 + k) % 8));
    end
    step(1'b1, NOP, 2'd0, 12'h000, 4'h0);
    chk("R6 end", 64'(v_o), 64'h0);

    // R9 single-bank precharge
    step(1'b1, PRE, 2'd3, 12'h000, 4'h0);
    chk("R9 single", 64'(act_o), 64'h0);
    chk("R3 pre code", 64'(cmd_o), 64'd2);

    // R8 single-beat write with auto close
    step(1'b1, MRS, 2'd0, 12'h000, 4'h0);
    step(1'b1, ACT, 2'd0, 12'h001, 4'h0);
    step(1'b1, WR, 2'd0, 12'h433, 4'h0);
    chk("R8 beat", 64'(v_o), 64'h1);
    chk("R8 col", 64'(c_o), 64'h33);
    chk("R8 closed", 64'(act_o), 64'h0);
    step(1'b1, NOP, 2'd0, 12'h000, 4'h0);
    chk("R8 end", 64'(v_o), 64'h0);

    finish_run();
  end

endmodule